// File: doc/BRIEF.md
# Audio codec clock divider chain

This block derives the converter master clock and the sample-rate word clock from an external reference when the synthesizer path is bypassed. A select field picks the master clock input or the bit clock input as the source. The ratio stage then makes a codec clock at 2/Q times the source frequency, which is 256 times the reference sample rate. The frame stage divides the codec clock down to the word clock, at the reference rate divided by a factor that moves in half steps.

Both reference inputs are slow clocks relative to the block's fast system clock. They are synchronized, and every edge of the chosen source, rising or falling, counts as one source half-cycle. Counting half-cycles gives the ratio stage the resolution it needs for odd Q. Settings are read from the configuration inputs only at a frame boundary, or at any cycle while the block is idle. A setting that is not legal raises a flag and holds both clocks low.

Top module: `acd_clkdiv_top`

## Requirements
- R1: After reset, codec_clk, word_clk and cfg_err are all low.
- R2: The encoding of cfg_sel is 0 for mclk_in and 1 for bclk_in. Codes 2 and 3 are not legal.
- R3: For Q = cfg_q in 2..17, one codec_clk period lasts Q source half-cycles. Of these, the first ceil(Q/2) are high.
- R4: The factor code k = cfg_ndac works as follows. Code 0 is dual rate (factor 0.5). Codes 1..11 give a factor of (k+1)/2. One word_clk period lasts CYC_PER_STEP·(k+1) codec_clk cycles (128·(k+1) by default, which is 256 times the factor). The word clock is high for the first half of the frame.
- R5: Every word_clk edge, rising or falling, falls on a codec_clk rising edge.
- R6: Any of the following raises cfg_err and holds both clocks low:
  - Q below 2 or above 17.
  - A factor code above 11.
  - A select code of 2 or 3.
  - An odd Q combined with a fractional factor (an even code of 2 or more).
- R7: While cfg_err is high, a legal setting clears the flag one clock after it is applied. A new frame then starts at the next source edge.
- R8: A change of any setting during a frame has no effect until that frame ends. This includes the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mclk_in | input | 1 | Master clock reference |
| bclk_in | input | 1 | Bit clock reference |
| cfg_sel | input | 2 | Source select |
| cfg_q | input | 5 | Ratio Q |
| cfg_ndac | input | 4 | Word-clock factor code |
| codec_clk | output | 1 | Codec master clock |
| word_clk | output | 1 | Word clock |
| cfg_err | output | 1 | Illegal setting flag |

## Verification
The bench builds the block with CYC_PER_STEP = 4, so a frame spans at most 48 codec cycles instead of 1536. This makes it possible to sweep every Q from 2 to 17 and every factor code on both sources, measuring frame period, duty and codec cycle count in clock cycles for each. The two sources toggle at different rates, so the measured periods also show which source was selected. The short frames also make room for each illegal class, the recovery from it, and a setting change in the middle of a frame.

// File: rtl/acd_pkg.sv
package acd_pkg;
  localparam int QW         = 5;
  localparam int NW         = 4;
  localparam int SW         = 2;
  localparam int NSRC       = 2;
  localparam int Q_LO       = 2;
  localparam int Q_HI       = 17;
  localparam int NDAC_CODES = 12;

  function automatic logic cfg_legal(input logic [SW-1:0] sel,
                                     input logic [QW-1:0] q,
                                     input logic [NW-1:0] n);
    logic ok;
    ok = (sel < SW'(NSRC)) &&
         (q >= QW'(Q_LO)) && (q <= QW'(Q_HI)) &&
         (n < NW'(NDAC_CODES)) &&
         !(q[0] && (n >= NW'(2)) && !n[0]);
    return ok;
  endfunction
endpackage

// File: rtl/acd_edge_det.sv
module acd_edge_det #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src,
  output logic edge_ev
);
  logic [SYNC-1:0] sync_q, sync_d;
  logic            prev_q, prev_d;

  always_comb begin
    sync_d = {sync_q[SYNC-2:0], src};
    prev_d = sync_q[SYNC-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  // one event per source transition of either polarity
  assign edge_ev = sync_q[SYNC-1] ^ prev_q;
endmodule

// File: rtl/acd_ratio_div.sv
module acd_ratio_div #(
  parameter int QW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          restart,
  input  logic          step,
  input  logic [QW-1:0] q,
  output logic          cclk,
  output logic          wrap
);
  logic [QW-1:0] h_q, h_d;
  logic          c_q, c_d;
  logic [QW:0]   hi_len;

  assign hi_len = ({1'b0, q} + 1'b1) >> 1;
  assign wrap   = (h_q == (q - 1'b1));

  always_comb begin
    h_d = h_q;
    c_d = c_q;
    if (clr) begin
      h_d = '0;
      c_d = 1'b0;
    end else if (restart) begin
      h_d = '0;
      c_d = 1'b1;
    end else if (step) begin
      h_d = wrap ? '0 : h_q + 1'b1;
      c_d = ({1'b0, h_d} < hi_len);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q <= '0;
      c_q <= 1'b0;
    end else begin
      h_q <= h_d;
      c_q <= c_d;
    end
  end

  assign cclk = c_q;
endmodule

// File: rtl/acd_frame_div.sv
module acd_frame_div #(
  parameter int UNIT = 128,
  parameter int NW   = 4,
  parameter int FW   = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          restart,
  input  logic          step,
  input  logic [NW-1:0] ndac,
  output logic          wclk,
  output logic          last
);
  localparam int FLW = FW + 1;

  logic [FW-1:0]  c_q, c_d;
  logic           w_q, w_d;
  logic [FLW-1:0] flen, half;

  assign flen = FLW'(UNIT) * (FLW'(ndac) + FLW'(1));
  assign half = flen >> 1;
  assign last = ({1'b0, c_q} == (flen - 1'b1));

  always_comb begin
    c_d = c_q;
    w_d = w_q;
    if (clr) begin
      c_d = '0;
      w_d = 1'b0;
    end else if (restart) begin
      c_d = '0;
      w_d = 1'b1;
    end else if (step) begin
      c_d = c_q + 1'b1;
      w_d = ({1'b0, c_d} < half);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_q <= '0;
      w_q <= 1'b0;
    end else begin
      c_q <= c_d;
      w_q <= w_d;
    end
  end

  assign wclk = w_q;
endmodule

// File: rtl/acd_clkdiv_top.sv
module acd_clkdiv_top
  import acd_pkg::*;
#(
  parameter int CYC_PER_STEP = 128,
  parameter int SYNC         = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mclk_in,
  input  logic          bclk_in,
  input  logic [SW-1:0] cfg_sel,
  input  logic [QW-1:0] cfg_q,
  input  logic [NW-1:0] cfg_ndac,
  output logic          codec_clk,
  output logic          word_clk,
  output logic          cfg_err
);
  localparam int FW = $clog2(CYC_PER_STEP * NDAC_CODES);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  // source edge events
  logic [NSRC-1:0] srcs, src_ev;
  assign srcs = {bclk_in, mclk_in};
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    acd_edge_det #(.SYNC(SYNC)) u_ed (
      .clk(clk), .rst_n(rst_i), .src(srcs[g]), .edge_ev(src_ev[g])
    );
  end

  // active settings and control
  logic [SW-1:0] sel_q, sel_d;
  logic [QW-1:0] q_q, q_d;
  logic [NW-1:0] n_q, n_d;
  logic          run_q, run_d, err_q, err_d, st_q, st_d;
  logic          cfg_ok, ev, wrap, last, boundary, load;
  logic          restart, clr, step_r, step_f;

  assign cfg_ok   = cfg_legal(cfg_sel, cfg_q, cfg_ndac);
  assign ev       = run_q & ((sel_q == SW'(1)) ? src_ev[1] : src_ev[0]);
  assign boundary = st_q & ev & wrap & last;
  assign load     = ~run_q | boundary;
  assign restart  = ev & (~st_q | (boundary & cfg_ok));
  assign clr      = ~run_q | (boundary & ~cfg_ok);
  assign step_r   = ev & st_q;
  assign step_f   = ev & st_q & wrap;

  always_comb begin
    sel_d = sel_q;
    q_d   = q_q;
    n_d   = n_q;
    run_d = run_q;
    err_d = err_q;
    st_d  = st_q;
    if (load) begin
      sel_d = cfg_sel;
      q_d   = cfg_q;
      n_d   = cfg_ndac;
      run_d = cfg_ok;
      err_d = ~cfg_ok;
    end
    if (!run_q)        st_d = 1'b0;
    else if (boundary) st_d = cfg_ok;
    else if (ev)       st_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      sel_q <= '0;
      q_q   <= '0;
      n_q   <= '0;
      run_q <= 1'b0;
      err_q <= 1'b0;
      st_q  <= 1'b0;
    end else begin
      sel_q <= sel_d;
      q_q   <= q_d;
      n_q   <= n_d;
      run_q <= run_d;
      err_q <= err_d;
      st_q  <= st_d;
    end
  end

  acd_ratio_div #(.QW(QW)) u_ratio (
    .clk(clk), .rst_n(rst_i), .clr(clr), .restart(restart), .step(step_r),
    .q(q_q), .cclk(codec_clk), .wrap(wrap)
  );

  acd_frame_div #(.UNIT(CYC_PER_STEP), .NW(NW), .FW(FW)) u_frame (
    .clk(clk), .rst_n(rst_i), .clr(clr), .restart(restart), .step(step_f),
    .ndac(n_q), .wclk(word_clk), .last(last)
  );

  assign cfg_err = err_q;
endmodule

// File: rtl/acd_clkdiv_chk.sv
module acd_clkdiv_chk (
  input logic clk,
  input logic rst_n,
  input logic codec_clk,
  input logic word_clk,
  input logic cfg_err
);
  AST_ERR_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (!codec_clk && !word_clk)); // R6

  AST_FRAME_START_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(word_clk) |-> $rose(codec_clk)); // R5

  AST_FRAME_MID_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(word_clk) && !cfg_err) |-> $rose(codec_clk)); // R4

  AST_ERR_NO_RUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_err) |-> (!$past(word_clk) && !$past(codec_clk))); // R8
endmodule

bind acd_clkdiv_top acd_clkdiv_chk u_chk (
  .clk(clk), .rst_n(rst_n), .codec_clk(codec_clk),
  .word_clk(word_clk), .cfg_err(cfg_err)
);

// File: tb/sim_acd_clkdiv_top.sv
`timescale 1ns/1ps
module sim_acd_clkdiv_top;
  localparam int CLK_PERIOD = 10;
  localparam int BUNIT      = 4;
  localparam int TMO        = 20000;
  localparam int WD_CYCLES  = 190000;

  logic       clk, rst_n, mclk_in, bclk_in, src_en;
  logic [1:0] cfg_sel;
  logic [4:0] cfg_q;
  logic [3:0] cfg_ndac;
  logic       codec_clk, word_clk, cfg_err;
  int         n_cmp, n_bad;

  acd_clkdiv_top #(.CYC_PER_STEP(BUNIT), .SYNC(2)) u0 (
    .clk(clk), .rst_n(rst_n), .mclk_in(mclk_in), .bclk_in(bclk_in),
    .cfg_sel(cfg_sel), .cfg_q(cfg_q), .cfg_ndac(cfg_ndac),
    .codec_clk(codec_clk), .word_clk(word_clk), .cfg_err(cfg_err)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  // mclk: 2 clk per half-cycle, bclk: 3 clk per half-cycle
  initial begin
    mclk_in = 1'b0;
    wait (src_en);
    forever begin repeat (2) @(negedge clk); mclk_in = ~mclk_in; end
  end
  initial begin
    bclk_in = 1'b0;
    wait (src_en);
    forever begin repeat (3) @(negedge clk); bclk_in = ~bclk_in; end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input int s, input int q, input int c);
    cfg_sel  = 2'(s);
    cfg_q    = 5'(q);
    cfg_ndac = 4'(c);
  endtask

  task automatic wait_rise(input string tag);
    bit p, ok;
    p = word_clk; ok = 1'b0;
    for (int i = 0; i < TMO && !ok; i++) begin
      @(negedge clk);
      if (!p && word_clk) ok = 1'b1;
      p = word_clk;
    end
    if (!ok) chk({tag, " R4 word clock rise seen"}, 0, 1);
  endtask

  // called on the sample where word_clk has just risen
  task automatic measure(input string tag, input int s, input int q, input int c,
                         input int chg_at, input int ns, input int nq, input int nc);
    int per, whi, chi, crise, viol, p, f;
    bit pw, pc, done;
    per = 1; crise = 1; viol = 0; done = 1'b0;
    whi = int'(word_clk); chi = int'(codec_clk);
    pw = word_clk; pc = codec_clk;
    for (int i = 0; i < TMO && !done; i++) begin
      @(negedge clk);
      if (i == chg_at) set_cfg(ns, nq, nc);
      if ((word_clk != pw) && !(codec_clk && !pc)) viol++;
      if (!pw && word_clk) done = 1'b1;
      else begin
        per++;
        whi += int'(word_clk);
        chi += int'(codec_clk);
        if (!pc && codec_clk) crise++;
      end
      pw = word_clk; pc = codec_clk;
    end
    p = (s == 1) ? 3 : 2;
    f = BUNIT * (c + 1);
    chk({tag, " R4 frame period"}, per, f * q * p);
    chk({tag, " R4 word high"}, whi, (f / 2) * q * p);
    chk({tag, " R4 codec cycles per frame"}, crise, f);
    chk({tag, " R3 codec high time"}, chi, f * ((q + 1) / 2) * p);
    chk({tag, " R5 edge alignment"}, viol, 0);
  endtask

  task automatic run_cfg(input string tag, input int s, input int q, input int c);
    set_cfg(s, q, c);
    wait_rise(tag);
    wait_rise(tag);
    measure(tag, s, q, c, -1, 0, 0, 0);
  endtask

  task automatic err_case(input string tag, input int s, input int q, input int c);
    int bad;
    bit seen;
    set_cfg(s, q, c);
    repeat (3) @(negedge clk);
    chk({tag, " R8 flag waits for boundary"}, int'(cfg_err), 0);
    chk({tag, " R8 frame continues"}, int'(word_clk), 1);
    seen = 1'b0;
    for (int i = 0; i < TMO && !seen; i++) begin
      @(negedge clk);
      if (cfg_err) seen = 1'b1;
    end
    chk({tag, " R6 flag raised"}, int'(seen), 1);
    bad = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (codec_clk || word_clk || !cfg_err) bad++;
    end
    chk({tag, " R6 clocks held low"}, bad, 0);
    set_cfg(0, 8, 3);
    repeat (2) @(negedge clk);
    chk({tag, " R7 flag cleared"}, int'(cfg_err), 0);
    wait_rise(tag);
    measure({tag, " R7 recovery"}, 0, 8, 3, -1, 0, 0, 0);
  endtask

  initial begin
    n_cmp = 0; n_bad = 0; src_en = 1'b0;
    rst_n = 1'b0;
    set_cfg(0, 4, 1);
    repeat (4) @(negedge clk);
    chk("R1 codec low in reset", int'(codec_clk), 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk("R1 codec low after reset", int'(codec_clk), 0);
    chk("R1 word low after reset", int'(word_clk), 0);
    chk("R1 flag low after reset", int'(cfg_err), 0);
    src_en = 1'b1;

    // R3 sweep of every Q, dual rate and unit factor, master clock
    for (int q = 2; q <= 17; q++)
      for (int c = 0; c < 2; c++)
        run_cfg($sformatf("R3 q%0d n%0d", q, c), 0, q, c);

    // R4 every factor code, even Q, bit clock (R2)
    for (int c = 0; c < 12; c++)
      run_cfg($sformatf("R2 bclk q4 n%0d", c), 1, 4, c);
    // odd Q with whole factors only
    for (int c = 0; c < 12; c++)
      if (c == 0 || (c % 2) == 1)
        run_cfg($sformatf("R2 bclk q3 n%0d", c), 1, 3, c);
    run_cfg("R3 bclk q17 n11", 1, 17, 11);
    run_cfg("R2 mclk q17 n11", 0, 17, 11);

    // R8 change during a frame: current frame keeps old setting
    run_cfg("R8 base", 0, 4, 1);
    measure("R8 in-flight", 0, 4, 1, 10, 0, 6, 3);
    measure("R8 applied", 0, 6, 3, -1, 0, 0, 0);

    run_cfg("R6 base", 0, 8, 3);
    err_case("R6 oddq frac", 0, 3, 2);
    err_case("R6 oddq frac5", 0, 5, 10);
    err_case("R6 q1", 0, 1, 1);
    err_case("R6 q0", 0, 0, 1);
    err_case("R6 q18", 0, 18, 1);
    err_case("R6 code12", 0, 4, 12);
    err_case("R2 sel2", 2, 4, 1);
    err_case("R2 sel3", 3, 4, 1);

    summary();
    $finish;
  end
endmodule